// File: doc/BRIEF.md
# Operand Addressing Mode Unit

This unit resolves the operand of one instruction. It takes a 4-bit mode code, an address field, a register specifier, the current instruction address and the accumulator value. From these it produces the effective address and the operand value. A small sequencer handles eleven modes:

- implied
- immediate
- direct
- indirect
- register direct
- register indirect
- post-increment
- pre-decrement
- indexed
- base-register
- PC-relative

The unit reads the register file through one combinational read port. It reads data memory through a single-port valid/ready interface. The pointer modes also write the stepped pointer back to the register file, with no separate arithmetic unit.

A request is taken only while `req_ready_o` is high. The result appears on `ea_o` and `operand_o` during the single cycle in which `done_o` is high. Displacements are sign-extended to the data width, and every address sum wraps modulo 2^XW. Memory returns `mem_rdata_i` in the same cycle it raises `mem_ready_i`.

Top module: `operand_addr_unit`

## Requirements
- R1: After reset `req_ready_o`=1 and `done_o`, `mem_valid_o`, `rf_we_o` and `illegal_o` are 0. A request is accepted on a clock edge with `req_valid_i` and `req_ready_o` both high, and `req_ready_o` is then low until the cycle after `done_o`. A `req_valid_i` pulse while busy is ignored and does not alter the result in progress.
- R2: Mode 0 (implied) returns the `acc_i` value captured at acceptance as the operand, with `ea_o`=0 and no memory read. `done_o` rises two edges after acceptance.
- R3: Mode 1 (immediate) returns the zero-extended field as the operand, with `ea_o`=0 and no memory read.
- R4: Mode 2 (direct) performs one read at the zero-extended field. `ea_o` is that address and the operand is the returned word.
- R5: Mode 3 (indirect) first reads at the zero-extended field. It then reads again at the returned word, which becomes `ea_o`. The second read's data is the operand.
- R6: Mode 4 (register direct) returns the content of register `req_reg_i` with no memory read and `ea_o`=0. Mode 5 (register indirect) reads memory at that content.
- R7: Mode 6 (post-increment) reads at the register content. It then writes back content+STEP to the same register.
- R8: Mode 7 (pre-decrement) reads at content-STEP and writes that value back to the register.
- R9: Modes 8 (indexed) and 9 (base) read at sign-extended field + register content, modulo 2^XW.
- R10: Mode 10 (PC-relative) reads at `req_pc_i` + INSN_BYTES + sign-extended field. For example, pc 398 with field 450 gives 850.
- R11: While `mem_valid_o` is high and `mem_ready_i` is low, `mem_valid_o` and `mem_addr_o` hold. Each cycle with both high completes exactly one read.
- R12: `done_o` lasts exactly one cycle. `rf_we_o` is high only in that cycle and only for modes 6 and 7.
- R13: Modes 11 to 15 raise `illegal_o` together with `done_o`. They make no memory read and no register write, and give `ea_o`=0 and `operand_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_ready_o | output | 1 | Unit idle, request can be taken |
| req_mode_i | input | 4 | Addressing mode code |
| req_field_i | input | FW | Address field / displacement |
| req_reg_i | input | RW | Register specifier |
| req_pc_i | input | XW | Address of the current instruction |
| acc_i | input | XW | Implicit accumulator value |
| rf_raddr_o | output | RW | Register file read index |
| rf_rdata_i | input | XW | Register file read data |
| rf_we_o | output | 1 | Pointer write-back strobe |
| rf_waddr_o | output | RW | Write-back register index |
| rf_wdata_o | output | XW | Write-back value |
| mem_valid_o | output | 1 | Memory read request |
| mem_addr_o | output | XW | Memory read address |
| mem_ready_i | input | 1 | Memory read completes, data valid |
| mem_rdata_i | input | XW | Memory read data |
| done_o | output | 1 | Result valid, one cycle |
| illegal_o | output | 1 | Unused mode code seen |
| ea_o | output | XW | Effective address |
| operand_o | output | XW | Operand value |

## Verification
The assertions take for granted that the memory side answers in the same cycle it raises ready, and that the register file read is combinational. They also assume the register file keeps its contents while a request is in flight. The bench keeps to this with a behavioural memory whose data is a pure function of the address, and a register array written only through the unit's write-back port. Ready is driven either constantly high or from a pseudo-random sequence at the falling edge, so that stalls fall before both the pointer read and the operand read. Request pulses are also injected while the unit is busy.

// File: rtl/oau_pkg.sv
package oau_pkg;
  localparam logic [3:0] MODE_IMPL  = 4'd0;
  localparam logic [3:0] MODE_IMM   = 4'd1;
  localparam logic [3:0] MODE_DIR   = 4'd2;
  localparam logic [3:0] MODE_IND   = 4'd3;
  localparam logic [3:0] MODE_REG   = 4'd4;
  localparam logic [3:0] MODE_RIND  = 4'd5;
  localparam logic [3:0] MODE_AINC  = 4'd6;
  localparam logic [3:0] MODE_ADEC  = 4'd7;
  localparam logic [3:0] MODE_IDX   = 4'd8;
  localparam logic [3:0] MODE_BASE  = 4'd9;
  localparam logic [3:0] MODE_PCREL = 4'd10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVAL,
    ST_PTR,
    ST_OPND,
    ST_DONE
  } oau_state_e;

  typedef struct packed {
    logic illegal;
    logic from_acc;
    logic from_field;
    logic from_reg;
    logic ptr_read;
    logic opnd_read;
    logic wb_en;
  } oau_ctl_t;
endpackage

// File: rtl/oau_decode.sv
module oau_decode
  import oau_pkg::*;
(
  input  logic [3:0] mode_i,
  output oau_ctl_t   ctl_o
);
  always_comb begin
    ctl_o = '0;
    unique case (mode_i)
      MODE_IMPL:  ctl_o.from_acc   = 1'b1;
      MODE_IMM:   ctl_o.from_field = 1'b1;
      MODE_REG:   ctl_o.from_reg   = 1'b1;
      MODE_IND:   ctl_o.ptr_read   = 1'b1;
      MODE_DIR, MODE_RIND, MODE_IDX, MODE_BASE, MODE_PCREL:
                  ctl_o.opnd_read  = 1'b1;
      MODE_AINC, MODE_ADEC: begin
        ctl_o.opnd_read = 1'b1;
        ctl_o.wb_en     = 1'b1;
      end
      default:    ctl_o.illegal    = 1'b1;
    endcase
  end
endmodule

// File: rtl/oau_ea_calc.sv
module oau_ea_calc
  import oau_pkg::*;
#(
  parameter int XW         = 16,
  parameter int FW         = 10,
  parameter int STEP       = 2,
  parameter int INSN_BYTES = 2
) (
  input  logic [3:0]    mode_i,
  input  logic [FW-1:0] field_i,
  input  logic [XW-1:0] reg_val_i,
  input  logic [XW-1:0] pc_i,
  output logic [XW-1:0] field_z_o,
  output logic [XW-1:0] ea_o,
  output logic [XW-1:0] wb_val_o
);
  localparam logic [XW-1:0] STEP_V = XW'(STEP);
  localparam logic [XW-1:0] INSN_V = XW'(INSN_BYTES);

  logic [XW-1:0] field_s;
  logic [XW-1:0] dec_ptr;
  logic [XW-1:0] inc_ptr;

  generate
    if (FW < XW) begin : g_ext
      assign field_z_o = {{(XW-FW){1'b0}}, field_i};
      assign field_s   = {{(XW-FW){field_i[FW-1]}}, field_i};
    end else begin : g_trunc
      assign field_z_o = field_i[XW-1:0];
      assign field_s   = field_i[XW-1:0];
    end
  endgenerate

  assign dec_ptr = reg_val_i - STEP_V;
  assign inc_ptr = reg_val_i + STEP_V;

  always_comb begin
    unique case (mode_i)
      MODE_DIR, MODE_IND:    ea_o = field_z_o;
      MODE_RIND, MODE_AINC:  ea_o = reg_val_i;
      MODE_ADEC:             ea_o = dec_ptr;
      MODE_IDX, MODE_BASE:   ea_o = field_s + reg_val_i;
      MODE_PCREL:            ea_o = pc_i + INSN_V + field_s;
      default:               ea_o = '0;
    endcase
  end

  assign wb_val_o = (mode_i == MODE_ADEC) ? dec_ptr : inc_ptr;
endmodule

// File: rtl/oau_seq.sv
module oau_seq
  import oau_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  oau_ctl_t   ctl_i,
  input  logic       mem_ready_i,
  output oau_state_e state_o
);
  oau_state_e state_d;

  always_comb begin
    state_d = state_o;
    unique case (state_o)
      ST_IDLE: if (req_valid_i) state_d = ST_EVAL;
      ST_EVAL: begin
        if (ctl_i.ptr_read)       state_d = ST_PTR;
        else if (ctl_i.opnd_read) state_d = ST_OPND;
        else                      state_d = ST_DONE;
      end
      ST_PTR:  if (mem_ready_i) state_d = ST_OPND;
      ST_OPND: if (mem_ready_i) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= ST_IDLE;
    else         state_o <= state_d;
  end
endmodule

// File: rtl/operand_addr_unit.sv
module operand_addr_unit
  import oau_pkg::*;
#(
  parameter int XW         = 16,
  parameter int FW         = 10,
  parameter int RW         = 3,
  parameter int STEP       = 2,
  parameter int INSN_BYTES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [3:0]    req_mode_i,
  input  logic [FW-1:0] req_field_i,
  input  logic [RW-1:0] req_reg_i,
  input  logic [XW-1:0] req_pc_i,
  input  logic [XW-1:0] acc_i,
  output logic [RW-1:0] rf_raddr_o,
  input  logic [XW-1:0] rf_rdata_i,
  output logic          rf_we_o,
  output logic [RW-1:0] rf_waddr_o,
  output logic [XW-1:0] rf_wdata_o,
  output logic          mem_valid_o,
  output logic [XW-1:0] mem_addr_o,
  input  logic          mem_ready_i,
  input  logic [XW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic          illegal_o,
  output logic [XW-1:0] ea_o,
  output logic [XW-1:0] operand_o
);
  oau_state_e    state_q;
  oau_ctl_t      ctl;
  logic          accept;
  logic [3:0]    mode_q;
  logic [FW-1:0] field_q;
  logic [RW-1:0] reg_q;
  logic [XW-1:0] pc_q, acc_q;
  logic [XW-1:0] ea_q, opnd_q, wdata_q;
  logic          ill_q, we_q;
  logic [XW-1:0] field_z, ea_calc, wb_val;

  assign accept = req_valid_i && (state_q == ST_IDLE);

  oau_decode u_dec (
    .mode_i (mode_q),
    .ctl_o  (ctl)
  );

  oau_ea_calc #(
    .XW(XW), .FW(FW), .STEP(STEP), .INSN_BYTES(INSN_BYTES)
  ) u_ea (
    .mode_i    (mode_q),
    .field_i   (field_q),
    .reg_val_i (rf_rdata_i),
    .pc_i      (pc_q),
    .field_z_o (field_z),
    .ea_o      (ea_calc),
    .wb_val_o  (wb_val)
  );

  oau_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .ctl_i       (ctl),
    .mem_ready_i (mem_ready_i),
    .state_o     (state_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      field_q <= '0;
      reg_q   <= '0;
      pc_q    <= '0;
      acc_q   <= '0;
      ea_q    <= '0;
      opnd_q  <= '0;
      wdata_q <= '0;
      ill_q   <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          mode_q  <= req_mode_i;
          field_q <= req_field_i;
          reg_q   <= req_reg_i;
          pc_q    <= req_pc_i;
          acc_q   <= acc_i;
          ill_q   <= 1'b0;
          we_q    <= 1'b0;
        end
        ST_EVAL: begin
          ill_q   <= ctl.illegal;
          we_q    <= ctl.wb_en;
          wdata_q <= wb_val;
          if (ctl.ptr_read || ctl.opnd_read) ea_q <= ea_calc;
          else                               ea_q <= '0;
          if (ctl.from_acc)        opnd_q <= acc_q;
          else if (ctl.from_field) opnd_q <= field_z;
          else if (ctl.from_reg)   opnd_q <= rf_rdata_i;
          else                     opnd_q <= '0;
        end
        // pointer word becomes the effective address
        ST_PTR:  if (mem_ready_i) ea_q <= mem_rdata_i;
        ST_OPND: if (mem_ready_i) opnd_q <= mem_rdata_i;
        default: ;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign illegal_o   = done_o && ill_q;
  assign rf_we_o     = done_o && we_q;
  assign rf_waddr_o  = reg_q;
  assign rf_wdata_o  = wdata_q;
  assign rf_raddr_o  = reg_q;
  assign mem_valid_o = (state_q == ST_PTR) || (state_q == ST_OPND);
  assign mem_addr_o  = ea_q;
  assign ea_o        = ea_q;
  assign operand_o   = opnd_q;
endmodule

// File: rtl/oau_chk.sv
module oau_chk #(
  parameter int XW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          mem_valid_o,
  input logic [XW-1:0] mem_addr_o,
  input logic          mem_ready_i,
  input logic          done_o,
  input logic          illegal_o,
  input logic          rf_we_o
);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!mem_valid_o && !done_o));

  a_r1_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  a_r11_hold_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o)));

  a_r12_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r12_we_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> done_o);

  a_r13_illegal_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (done_o && !rf_we_o && !mem_valid_o));
endmodule

bind operand_addr_unit oau_chk #(.XW(XW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .mem_valid_o (mem_valid_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ready_i (mem_ready_i),
  .done_o      (done_o),
  .illegal_o   (illegal_o),
  .rf_we_o     (rf_we_o)
);

// File: tb/sim_operand_addr_unit.sv
`timescale 1ns/1ps
module sim_operand_addr_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [3:0]  req_mode_i = '0;
  logic [9:0]  req_field_i = '0;
  logic [2:0]  req_reg_i = '0;
  logic [15:0] req_pc_i = '0;
  logic [15:0] acc_i = '0;
  logic [2:0]  rf_raddr_o;
  logic [15:0] rf_rdata_i;
  logic        rf_we_o;
  logic [2:0]  rf_waddr_o;
  logic [15:0] rf_wdata_o;
  logic        mem_valid_o;
  logic [15:0] mem_addr_o;
  logic        mem_ready_i = 1'b1;
  logic [15:0] mem_rdata_i;
  logic        done_o, illegal_o;
  logic [15:0] ea_o, operand_o;

  always #4 clk_i = ~clk_i;

  operand_addr_unit u0 (.*);

  int checks = 0;
  int errors = 0;

  function automatic logic [15:0] mw(input logic [15:0] a);
    return a * 16'd40503 + 16'h1234;
  endfunction

  logic [15:0] brf [8];
  assign rf_rdata_i  = brf[rf_raddr_o];
  assign mem_rdata_i = mw(mem_addr_o);
  always @(posedge clk_i) if (rf_we_o) brf[rf_waddr_o] <= rf_wdata_o;

  // reference model: 0 idle, 1 eval, 2 reading, 3 done
  int          m_ph = 0;
  int          nrd, rdi;
  logic [15:0] e_ea, e_op, e_wd;
  logic [15:0] e_addr [2];
  logic        e_ill, e_we;
  logic [2:0]  e_wa;
  logic [15:0] exp_rf [8];

  task automatic predict();
    logic [15:0] fz, fs, rv;
    fz = {6'b0, req_field_i};
    fs = {{6{req_field_i[9]}}, req_field_i};
    rv = exp_rf[req_reg_i];
    e_ea = 0; e_op = 0; e_ill = 0; e_we = 0; e_wa = req_reg_i; e_wd = 0; nrd = 0;
    e_addr[0] = 0; e_addr[1] = 0;
    case (req_mode_i)
      0: e_op = acc_i;
      1: e_op = fz;
      2: begin e_ea = fz; nrd = 1; end
      3: begin e_addr[0] = fz; e_ea = mw(fz); e_addr[1] = e_ea; nrd = 2; end
      4: e_op = rv;
      5: begin e_ea = rv; nrd = 1; end
      6: begin e_ea = rv; nrd = 1; e_we = 1; e_wd = rv + 16'd2; end
      7: begin e_ea = rv - 16'd2; nrd = 1; e_we = 1; e_wd = e_ea; end
      8, 9: begin e_ea = fs + rv; nrd = 1; end
      10: begin e_ea = req_pc_i + 16'd2 + fs; nrd = 1; end
      default: e_ill = 1;
    endcase
    if (nrd == 1) e_addr[0] = e_ea;
    if (nrd > 0) e_op = mw(e_ea);
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) m_ph = 0;
    else case (m_ph)
      0: if (req_valid_i) begin predict(); m_ph = 1; end
      1: begin rdi = 0; m_ph = (nrd == 0) ? 3 : 2; end
      2: if (mem_ready_i) begin rdi = rdi + 1; if (rdi == nrd) m_ph = 3; end
      3: begin if (e_we) exp_rf[e_wa] = e_wd; m_ph = 0; end
      default: m_ph = 0;
    endcase
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  logic [3:0] cur_mode;
  function automatic string mtag(input logic [3:0] m);
    case (m)
      0: return "R2"; 1: return "R3"; 2: return "R4"; 3: return "R5";
      4, 5: return "R6"; 6: return "R7"; 7: return "R8";
      8, 9: return "R9"; 10: return "R10"; default: return "R13";
    endcase
  endfunction

  always @(negedge clk_i) if (rst_ni) begin
    chk(req_ready_o == (m_ph == 0), "R1 ready", 16'(req_ready_o), 16'(m_ph == 0));
    chk(done_o == (m_ph == 3), "R12 done", 16'(done_o), 16'(m_ph == 3));
    chk(mem_valid_o == (m_ph == 2), "R11 mem_valid", 16'(mem_valid_o), 16'(m_ph == 2));
    if (m_ph == 2)
      chk(mem_addr_o == e_addr[rdi], {mtag(cur_mode), " mem_addr"}, mem_addr_o, e_addr[rdi]);
    chk(rf_we_o == (m_ph == 3 && e_we), "R12 rf_we", 16'(rf_we_o), 16'(m_ph == 3 && e_we));
    chk(illegal_o == (m_ph == 3 && e_ill), "R13 illegal", 16'(illegal_o), 16'(m_ph == 3 && e_ill));
    if (m_ph == 3) begin
      chk(ea_o == e_ea, {mtag(cur_mode), " ea"}, ea_o, e_ea);
      chk(operand_o == e_op, {mtag(cur_mode), " operand"}, operand_o, e_op);
      if (e_we) begin
        chk(rf_waddr_o == e_wa, {mtag(cur_mode), " waddr"}, 16'(rf_waddr_o), 16'(e_wa));
        chk(rf_wdata_o == e_wd, {mtag(cur_mode), " wdata"}, rf_wdata_o, e_wd);
      end
    end
  end

  // stall pattern
  logic [15:0] lfsr = 16'hACE1;
  bit          rnd_ready = 0;
  always @(negedge clk_i) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready_i <= rnd_ready ? lfsr[0] : 1'b1;
  end

  task automatic issue(input logic [3:0] m, input logic [9:0] f, input logic [2:0] r,
                       input logic [15:0] pc, input logic [15:0] acc, input bit poke);
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    cur_mode = m;
    req_valid_i = 1; req_mode_i = m; req_field_i = f; req_reg_i = r;
    req_pc_i = pc; acc_i = acc;
    @(negedge clk_i);
    req_valid_i = 0;
    if (poke) begin
      // R1: stray request while busy must be ignored
      req_valid_i = 1; req_mode_i = 4'd1; req_field_i = 10'h155; acc_i = 16'hDEAD;
      @(negedge clk_i);
      req_valid_i = 0;
    end
    while (m_ph != 0) @(negedge clk_i);
  endtask

  task automatic run_set(input bit poke);
    issue(0, 10'h000, 0, 0, 16'h5A5A, poke);           // R2
    issue(1, 10'h3FF, 0, 0, 0, poke);                  // R3 zero-extend
    issue(2, 10'h123, 0, 0, 0, poke);                  // R4
    issue(3, 10'h0F0, 0, 0, 0, poke);                  // R5
    issue(4, 0, 3, 0, 0, poke);                        // R6 direct
    issue(5, 0, 2, 0, 0, poke);                        // R6 indirect
    issue(6, 0, 5, 0, 0, poke);                        // R7
    issue(4, 0, 5, 0, 0, poke);                        // R7 written value visible
    issue(7, 0, 6, 0, 0, poke);                        // R8
    issue(4, 0, 6, 0, 0, poke);                        // R8 written value visible
    issue(8, 10'h3F0, 1, 0, 0, poke);                  // R9 negative displacement
    issue(9, 10'h040, 7, 0, 0, poke);                  // R9
    issue(10, 10'd450, 0, 16'd398, 0, poke);           // R10 850
    issue(10, 10'h005, 0, 16'hFFFE, 0, poke);          // R10 wrap
    issue(10, 10'h3FC, 0, 16'h0100, 0, poke);          // R10 negative
    issue(11, 10'h001, 1, 0, 0, poke);                 // R13
    issue(15, 10'h002, 2, 0, 0, poke);                 // R13
    issue(4, 0, 1, 0, 0, poke);                        // R13 register untouched
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      brf[i] = 16'h1000 + 16'(i) * 16'h0111;
      exp_rf[i] = brf[i];
    end
    #1;
    chk(req_ready_o == 1 && done_o == 0 && mem_valid_o == 0 && rf_we_o == 0 && illegal_o == 0,
        "R1 reset state", {11'b0, req_ready_o, done_o, mem_valid_o, rf_we_o, illegal_o}, 16'h0010);
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R2 latency: done two edges after acceptance
    @(negedge clk_i);
    cur_mode = 0;
    req_valid_i = 1; req_mode_i = 0; acc_i = 16'h0077;
    @(negedge clk_i); req_valid_i = 0;
    chk(done_o == 0, "R2 latency edge1", 16'(done_o), 16'd0);
    @(negedge clk_i);
    chk(done_o == 1 && operand_o == 16'h0077, "R2 latency edge2", operand_o, 16'h0077);
    @(negedge clk_i);
    run_set(0);
    rnd_ready = 1;
    for (int k = 0; k < 6; k++) run_set(k[0]);
    rnd_ready = 0;
    run_set(1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog (R1) actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule